// File: doc/BRIEF.md
# Delay-Span Phase Detector

This block is the phase detector of a delay-locked loop whose delay line has a fixed number of taps. It does not just compare the reference edge against the last tap. It times the whole span of the line. A reference rising edge opens a measurement window. The window is carried tap by tap through a chain of flops, one flop per tap edge, and it closes when the last tap edge arrives. The result is a window output that is high for exactly the measured line delay.

A one-bit overrun flag samples the window on every reference rising edge. When the flag is low, only the down pulse may fire, and that pulse covers the part of the period after the window has closed. When the flag is high, the line delay has run past one reference period, so only the up pulse may fire, and it covers the rest of the window. Because of this gating, a line that is much too slow can never be pushed slower, and a line that is too fast can never be pushed faster. Harmonic lock and lock at either end of the range are therefore ruled out. The charge pump, the loop filter and the analog delay cells sit outside this block.

Top module: `delay_span_pd`

## Requirements
- R1: While `rst_n` is low at reference rising edges, `overrun_o`, `window_o`, `up_o` and `dn_o` all read 0. Both pulse outputs also stay 0 after release until the first reference rising edge.
- R2: A reference rising edge at which no measurement is in progress starts one: `window_o` goes high right after that edge.
- R3: The capture chain is filled strictly in tap order, so a flop for a later tap is never set while the flop before it is clear. `window_o` falls on the rising edge of the last tap (index NUM_TAPS-1 of `tap_clk`), and the whole chain is then clear.
- R4: Reference edges that arrive while `window_o` is high do not restart the measurement. The window therefore stays high for the full line delay, even when that delay is several reference periods long.
- R5: On every reference rising edge, `overrun_o` takes the value that `window_o` had just before that edge.
- R6: With `overrun_o` = 0, `up_o` = 0 and `dn_o` = NOT `window_o`. With `overrun_o` = 1, `up_o` = `window_o` and `dn_o` = 0.
- R7: If the line delay is shorter than one reference period, `overrun_o` stays 0, only down pulses appear, and one appears every period.
- R8: If the line delay lies between one and two reference periods, `overrun_o` alternates 0,1 starting with 0. One up pulse appears every two periods, and no down pulse appears.
- R9: If the line delay is longer than two (and shorter than three) reference periods, `overrun_o` repeats 0,1,1 and only up pulses appear.
- R10: `up_o` and `dn_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, applied in each flop's own clock domain |
| ref_clk | input | 1 | Reference clock; its rising edge starts a measurement and updates the overrun flag |
| tap_clk | input | NUM_TAPS | Delay-line tap outputs; bit k is the output of cell k+1, and bit NUM_TAPS-1 is the line output |
| up_o | output | 1 | Speed-up request to the charge pump (shortens the line delay) |
| dn_o | output | 1 | Slow-down request to the charge pump (lengthens the line delay) |
| window_o | output | 1 | Measured-delay window: high from the starting reference edge to the last tap edge |
| overrun_o | output | 1 | Window level sampled at the latest reference edge (1 = delay exceeded a period) |

## Verification
The bench keeps the default of eight taps and models the delay line as eight equal transport-delay stages. Their per-stage delay is set so that the total line delay is 0.6, 1.44 and 2.4 times the 5 ns reference period. These three settings bring each overrun pattern within reach: always 0, then 0,1, then 0,1,1. The third setting also keeps the window open across two reference edges, which exercises the no-restart rule. The window closes at a fraction of the period that differs from one setting to the next. Because of this, sampling twice per period catches both the up part and the down part of the outputs, and it also shows whether the window falls on the last tap edge.

// File: rtl/delay_span_pd_pkg.sv
// Package: shared definitions for the delay-span phase detector.
// Assumes: a single default tap count, overridable per instance.
package delay_span_pd_pkg;

    // Default number of delay-line taps observed by the detector.
    localparam int DEFAULT_TAPS = 8;

    // Meaning of the overrun flag sampled on each reference edge.
    typedef enum logic {
        SPAN_WITHIN = 1'b0,   // line delay closed before this edge
        SPAN_OVER   = 1'b1    // window still open at this edge
    } span_flag_e;

endpackage

// File: rtl/dspd_capture_chain.sv
// Module: capture chain of NUM_TAPS+1 set-and-shift flops.
// What it does: the head flop is set by a reference rising edge. Stage k is
// clocked by tap k-1 and copies stage k-1. Once the last stage is set, every
// flop is cleared asynchronously, so the chain is ready for the next edge.
// Assumes: each cell delay is shorter than one reference period, and reset is
// held across at least one edge of every tap.
module dspd_capture_chain #(
    parameter int NUM_TAPS = delay_span_pd_pkg::DEFAULT_TAPS
) (
    input  logic                rst_n,
    input  logic                ref_clk,
    input  logic [NUM_TAPS-1:0] tap_clk,
    output logic [NUM_TAPS:0]   chain_q
);
    localparam int LAST = NUM_TAPS;

    logic span_done;
    logic head_q;

    // Clear request raised by the final stage once the last tap has fired.
    assign span_done = chain_q[LAST];

    // Head flop: set by a reference edge; a set flop stays set, so a busy
    // chain is not restarted.
    always_ff @(posedge ref_clk or posedge span_done) begin
        if (span_done) begin
            head_q <= 1'b0;
        end else if (!rst_n) begin
            head_q <= 1'b0;
        end else begin
            head_q <= 1'b1;
        end
    end

    assign chain_q[0] = head_q;

    generate
        for (genvar k = 1; k <= NUM_TAPS; k++) begin : g_stage
            logic stage_q;

            // Stage flop: copies the previous stage on its own tap edge.
            always_ff @(posedge tap_clk[k-1] or posedge span_done) begin
                if (span_done) begin
                    stage_q <= 1'b0;
                end else if (!rst_n) begin
                    stage_q <= 1'b0;
                end else begin
                    stage_q <= chain_q[k-1];
                end
            end

            assign chain_q[k] = stage_q;

            // R3
            chain_order_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
                chain_q[k] |-> chain_q[k-1]);
        end
    endgenerate

endmodule

// File: rtl/dspd_window_state.sv
// Module: measurement window and overrun flag.
// What it does: the window is high while the head flop is set and the last
// stage is not. The overrun flop samples the window on every reference rising
// edge. The armed flop marks that at least one edge has passed since reset.
// Assumes: the chain ends come from dspd_capture_chain.
module dspd_window_state (
    input  logic rst_n,
    input  logic ref_clk,
    input  logic head_q,
    input  logic tail_q,
    output logic window_o,
    output logic overrun_o,
    output logic armed_o
);
    import delay_span_pd_pkg::*;

    span_flag_e flag_q;
    logic       armed_q;

    // Window: open from the start edge until the last tap arrives.
    assign window_o = head_q & ~tail_q;

    // Overrun flop: records whether the window was still open at this edge.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            flag_q <= SPAN_WITHIN;
        end else begin
            flag_q <= window_o ? SPAN_OVER : SPAN_WITHIN;
        end
    end

    // Armed flop: enables the pulse outputs after the first reference edge.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assign overrun_o = (flag_q == SPAN_OVER);
    assign armed_o   = armed_q;

    // R1
    reset_clear_chk: assert property (@(posedge ref_clk)
        !rst_n |=> (!overrun_o && !armed_q));

    // R2
    first_edge_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(armed_q) |-> !overrun_o);

    // R5
    overrun_armed_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        overrun_o |-> armed_q);

endmodule

// File: rtl/dspd_pulse_select.sv
// Module: up/down pulse selection.
// What it does: with the flag low, the down output follows the closed part of
// the period. With the flag high, the up output follows the open window.
// Nothing fires before the first reference edge after reset.
// Assumes: purely combinational; the inputs come from dspd_window_state.
module dspd_pulse_select (
    input  logic window_i,
    input  logic overrun_i,
    input  logic armed_i,
    output logic up_o,
    output logic dn_o
);
    // Selection: one leg per flag value, both gated by the armed flag.
    always_comb begin
        up_o = 1'b0;
        dn_o = 1'b0;
        if (armed_i) begin
            if (overrun_i) begin
                up_o = window_i;
            end else begin
                dn_o = ~window_i;
            end
        end
    end

endmodule

// File: rtl/delay_span_pd.sv
// Module: top of the delay-span phase detector.
// What it does: captures the full delay-line span, samples the window on each
// reference edge and steers the correction pulses.
// Assumes: tap_clk[k] is the output of cell k+1, in order along the line.
module delay_span_pd #(
    parameter int NUM_TAPS = delay_span_pd_pkg::DEFAULT_TAPS
) (
    input  logic                rst_n,
    input  logic                ref_clk,
    input  logic [NUM_TAPS-1:0] tap_clk,
    output logic                up_o,
    output logic                dn_o,
    output logic                window_o,
    output logic                overrun_o
);
    localparam int CHAIN_LEN = NUM_TAPS + 1;

    logic [CHAIN_LEN-1:0] chain_q;
    logic                 armed;

    // Capture chain: one flop per tap plus the head.
    dspd_capture_chain #(.NUM_TAPS(NUM_TAPS)) u_chain (
        .rst_n   (rst_n),
        .ref_clk (ref_clk),
        .tap_clk (tap_clk),
        .chain_q (chain_q)
    );

    // Window and overrun flag.
    dspd_window_state u_state (
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .head_q    (chain_q[0]),
        .tail_q    (chain_q[CHAIN_LEN-1]),
        .window_o  (window_o),
        .overrun_o (overrun_o),
        .armed_o   (armed)
    );

    // Pulse selection.
    dspd_pulse_select u_sel (
        .window_i  (window_o),
        .overrun_i (overrun_o),
        .armed_i   (armed),
        .up_o      (up_o),
        .dn_o      (dn_o)
    );

    // R10
    pulse_exclusive_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(up_o && dn_o));

    // R6
    up_in_window_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        up_o |-> window_o);

    // R6
    dn_out_window_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        dn_o |-> !window_o);

endmodule

// File: tb/delay_span_pd_tb.sv
`timescale 1ns/1ps
module delay_span_pd_tb;
    localparam int  NT     = 8;
    localparam real HALF   = 2.5;
    localparam int  NEDGES = 30;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    real  stage_ns = 0.5;
    wire  [NT:0] tw;
    logic up, dn, win, ovr;
    int   total_chk = 0;
    int   bad_chk   = 0;

    // Behavioural reference model state.
    realtime m_end   = -1.0;
    bit      m_state = 1'b0;
    bit      m_armed = 1'b0;

    always #(HALF) ref_clk = ~ref_clk;

    // Delay line model: eight transport-delay stages.
    assign tw[0] = ref_clk;
    generate
        for (genvar k = 1; k <= NT; k++) begin : g_cell
            logic t = 1'b0;
            always @(tw[k-1]) t <= #(stage_ns) tw[k-1];
            assign tw[k] = t;
        end
    endgenerate

    delay_span_pd #(.NUM_TAPS(NT)) u_dut (
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .tap_clk   (tw[NT:1]),
        .up_o      (up),
        .dn_o      (dn),
        .window_o  (win),
        .overrun_o (ovr)
    );

    // Model update on every reference edge: timestamps, not flops.
    always @(posedge ref_clk) begin
        if (!rst_n) begin
            m_state = 1'b0;
            m_armed = 1'b0;
            m_end   = -1.0;
        end else begin
            m_state = ($realtime < m_end);
            m_armed = 1'b1;
            if (!m_state) m_end = $realtime + NT * stage_ns;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total_chk++;
        if (act !== exp) begin
            bad_chk++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        total_chk++;
        if (act != exp) begin
            bad_chk++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model at the current time.
    task automatic compare_now();
        logic md_e;
        md_e = m_armed && ($realtime < m_end);
        chk("R5 overrun follows window at edge", ovr, m_state);
        chk("R2 R3 R4 window level", win, md_e);
        chk("R6 up selection", up, m_armed && m_state && md_e);
        chk("R6 dn selection", dn, m_armed && !m_state && !md_e);
        chk("R10 up/dn exclusive", up && dn, 1'b0);
    endtask

    task automatic run_case(input real total_ns, output int ones,
                            output int ups, output int dns);
        ones = 0; ups = 0; dns = 0;
        @(negedge ref_clk);
        rst_n = 1'b0;
        stage_ns = total_ns / NT;
        repeat (6) @(posedge ref_clk);
        #1.0;
        chk("R1 reset overrun", ovr, 1'b0);
        chk("R1 reset window", win, 1'b0);
        chk("R1 reset up", up, 1'b0);
        chk("R1 reset dn", dn, 1'b0);
        @(negedge ref_clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 up idle before first edge", up, 1'b0);
        chk("R1 dn idle before first edge", dn, 1'b0);
        for (int e = 0; e < NEDGES; e++) begin
            @(posedge ref_clk);
            #1.0;
            compare_now();
            if (ovr === 1'b1) ones++;
            if (up === 1'b1) ups++;
            if (dn === 1'b1) dns++;
            #2.5;
            compare_now();
            if (up === 1'b1) ups++;
            if (dn === 1'b1) dns++;
        end
    endtask

    initial begin
        int ones, ups, dns;
        // Short line: 3.0 ns total, window closes 3.0 ns into each period.
        run_case(3.0, ones, ups, dns);
        chk_int("R7 overrun never set", ones, 0);
        chk_int("R7 no up samples", ups, 0);
        chk_int("R7 one dn sample per period", dns, NEDGES);
        // Medium line: 7.2 ns total, pattern 0,1.
        run_case(7.2, ones, ups, dns);
        chk_int("R8 overrun alternates", ones, NEDGES / 2);
        chk_int("R8 no dn samples", dns, 0);
        chk_int("R8 one up sample every two periods", ups, NEDGES / 2);
        // Long line: 12.0 ns total, pattern 0,1,1.
        run_case(12.0, ones, ups, dns);
        chk_int("R9 overrun pattern 0,1,1", ones, (2 * NEDGES) / 3);
        chk_int("R9 no dn samples", dns, 0);
        chk_int("R9 up samples", ups, NEDGES);
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5.0);
        bad_chk++;
        total_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule